// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates five interrupt requests on behalf of a small 8-bit processor core. The sources are one non-maskable trap, three restart requests with fixed vectors, and one general request whose branch target the interrupting device supplies. Each source is conditioned by its own trigger rule. The controller applies per-source mask bits and a global enable, and when the core asserts its sample strobe it picks the single highest-priority eligible source.

One cycle after the sample edge the controller pulses an accept strobe. In that same cycle it presents either the fixed restart address of the winner, or, for the general source, a flag telling the core to run a device acknowledge cycle. It also clears whatever latch the winner consumed. It does not fetch, decode or stack anything; it only tells the core where to branch.

A 7-bit configuration write port sets the mask bits and the enable, and can discard a captured edge. An 8-bit status word exposes the masks, the enable and the pending state.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The trap source ignores every mask bit and the global enable, and beats all other sources. When it is accepted, `vec_o` is 0x24 and `ext_o` is 0.
- R2: A trap is taken only if a rising edge of `nmi_i` was seen at an earlier clock edge and `nmi_i` is still high at the sample edge. If the input falls before sampling, the trap is dropped for good.
- R3: One continuous high pulse on `nmi_i` yields at most one trap. A new trap needs the input to go low and rise again.
- R4: A rising edge on `rq_a_i` is latched and stays pending after the input falls, until it is accepted. It is accepted with vector 0x3C, and acceptance clears the latch (status bit 5).
- R5: `rq_b_i` (vector 0x34) and `rq_c_i` (vector 0x2C) are level-sensitive. Each must be high at the sample edge, and no memory of it is kept.
- R6: `rq_gen_i` has the lowest priority. When it is accepted, `ext_o` is 1 and `vec_o` is 0x00.
- R7: When several sources are eligible, the fixed order is trap, then `rq_a_i`, then `rq_b_i`, then `rq_c_i`, then `rq_gen_i`.
- R8: The mask bits are `cfg_data_i`[0] for `rq_a_i`, [1] for `rq_b_i` and [2] for `rq_c_i`. They are loaded when [3] is 1 during a write, and a value of 1 blocks that source. A masked `rq_a_i` edge stays latched.
- R9: The global enable is 0 after reset. A write with `cfg_data_i`[5]=1 loads it from [6]. While it is 0, only the trap can be accepted. Accepting any non-trap source clears it, and accepting the trap leaves it unchanged.
- R10: A write with `cfg_data_i`[4]=1 discards a latched `rq_a_i` edge.
- R11: `take_o` is a one-cycle pulse in the cycle after a clock edge at which `sample_i` was high and some source was eligible. Otherwise it stays 0, and `vec_o` and `ext_o` are then 0.
- R12: `status_o` bits [2:0] hold the masks in R8 order, bit 3 the enable, bit 4 an armed trap, bit 5 the `rq_a_i` latch, bit 6 `rq_b_i`, and bit 7 `rq_c_i`. The word is 0x00 after reset with all inputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_i | input | 1 | Non-maskable trap request |
| rq_a_i | input | 1 | Edge-latched restart request, vector 0x3C |
| rq_b_i | input | 1 | Level restart request, vector 0x34 |
| rq_c_i | input | 1 | Level restart request, vector 0x2C |
| rq_gen_i | input | 1 | General request, device-supplied vector |
| sample_i | input | 1 | Core sampling strobe |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 7 | Configuration word (fields in R8 to R10) |
| take_o | output | 1 | One-cycle accept strobe |
| vec_o | output | 8 | Restart address of the accepted source |
| ext_o | output | 1 | Accepted source needs a device acknowledge cycle |
| status_o | output | 8 | Mask, enable and pending status |

## Verification
The hardest condition to reach from the ports is a trap that is armed but never taken. One case is an input that rises and falls between two samples. The other is a pulse that is still high after its first acceptance. The stimulus places each `nmi_i` transition a whole clock before the sample strobe, so the edge detector has registered the rise. It then drops the input, or leaves it high, exactly across the sampling edge. A second hard case is a masked edge on `rq_a_i` that must survive in its latch, be discarded by a configuration write, and then never fire after unmasking.

// File: rtl/irq_pkg.sv
package irq_pkg;

   localparam int unsigned NSRC  = 5;
   localparam int unsigned NFIX  = 4;
   localparam int unsigned CFG_W = 7;

   typedef enum logic [1:0] {
      TRIG_EDGE_LEVEL = 2'd0,
      TRIG_EDGE_LATCH = 2'd1,
      TRIG_LEVEL      = 2'd2
   } trig_e;

   // Field layout of the configuration write word, MSB first.
   typedef struct packed {
      logic       ie_val;
      logic       ie_we;
      logic       clr_latch;
      logic       mask_we;
      logic [2:0] mask;
   } cfg_word_t;

   // Source index doubles as priority: 0 is the highest.
   function automatic trig_e trig_of(input int unsigned idx);
      case (idx)
         0:       return TRIG_EDGE_LEVEL;
         1:       return TRIG_EDGE_LATCH;
         default: return TRIG_LEVEL;
      endcase
   endfunction

endpackage

// File: rtl/irq_cond.sv
module irq_cond
   import irq_pkg::*;
#(
   parameter trig_e MODE = TRIG_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic consume_i,
   input  logic flush_i,
   output logic pend_o
);

   generate
      if (MODE == TRIG_LEVEL) begin : g_level
         wire unused_lvl = consume_i | flush_i | clk | rst_n;
         assign pend_o = req_i;

      end else if (MODE == TRIG_EDGE_LATCH) begin : g_latch
         logic prev_q, lat_q;
         wire  rise = req_i & ~prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               lat_q  <= 1'b0;
            end else begin
               prev_q <= req_i;
               lat_q  <= rise | (lat_q & ~consume_i & ~flush_i);
            end
         end
         assign pend_o = lat_q;

         // R4: a captured edge survives until consumed or discarded
         a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_q && !consume_i && !flush_i) |=> lat_q);
         // R10: discard empties the latch when no new edge arrives
         a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_i && !req_i) |=> !lat_q);

      end else begin : g_edge_level
         logic prev_q, lat_q;
         wire  rise = req_i & ~prev_q;
         wire  unused_el = flush_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               lat_q  <= 1'b0;
            end else begin
               prev_q <= req_i;
               lat_q  <= req_i & (rise | (lat_q & ~consume_i));
            end
         end
         assign pend_o = lat_q & req_i;

         // R2: a low input disarms the detector
         a_r2_low_disarms: assert property (@(posedge clk) disable iff (!rst_n)
            !req_i |=> !lat_q);
         // R3: consumption during a held pulse cannot re-arm
         a_r3_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
            (consume_i && req_i && prev_q) |=> !lat_q);
      end
   endgenerate

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned N = 5
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o,
   output logic         any_o
);

   always_comb begin
      logic found;
      found   = 1'b0;
      grant_o = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (req_i[i] && !found) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   assign any_o = |req_i;

endmodule

// File: rtl/irq_cfg.sv
module irq_cfg
   import irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_i,
   input  cfg_word_t  data_i,
   input  logic       maskable_take_i,
   output logic [2:0] mask_o,
   output logic       ie_o,
   output logic       flush_o
);

   logic [2:0] mask_q;
   logic       ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         ie_q   <= 1'b0;
      end else begin
         if (we_i && data_i.mask_we)
            mask_q <= data_i.mask;
         if (maskable_take_i)
            ie_q <= 1'b0;
         else if (we_i && data_i.ie_we)
            ie_q <= data_i.ie_val;
      end
   end

   assign mask_o  = mask_q;
   assign ie_o    = ie_q;
   assign flush_o = we_i & data_i.clr_latch;

   // R9: accepting a maskable source leaves the enable cleared
   a_r9_take_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
      maskable_take_i |=> !ie_q);
   // R8: masks move only on a write with the load bit set
   a_r8_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && data_i.mask_we) |=> $stable(mask_q));

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned VEC_TRAP = 'h24,
   parameter int unsigned VEC_RA   = 'h3C,
   parameter int unsigned VEC_RB   = 'h34,
   parameter int unsigned VEC_RC   = 'h2C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi_i,
   input  logic             rq_a_i,
   input  logic             rq_b_i,
   input  logic             rq_c_i,
   input  logic             rq_gen_i,
   input  logic             sample_i,
   input  logic             cfg_we_i,
   input  logic [CFG_W-1:0] cfg_data_i,
   output logic             take_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             ext_o,
   output logic [7:0]       status_o
);

   localparam int unsigned VEC_LIM = 1 << VEC_W;
   localparam int unsigned GEN_IDX = NSRC - 1;
   localparam logic [VEC_W-1:0] FIX_VEC [NFIX] = '{
      VEC_W'(VEC_TRAP), VEC_W'(VEC_RA), VEC_W'(VEC_RB), VEC_W'(VEC_RC)};

   generate
      if (VEC_W < 6 || VEC_W > 16) begin : g_bad_width
         $fatal(1, "vec_irq_ctrl: VEC_W out of range");
      end
      if (VEC_TRAP >= VEC_LIM || VEC_RA >= VEC_LIM ||
          VEC_RB >= VEC_LIM || VEC_RC >= VEC_LIM) begin : g_bad_vec
         $fatal(1, "vec_irq_ctrl: vector does not fit VEC_W");
      end
   endgenerate

   logic [NSRC-1:0] raw, pend, elig, grant, consume;
   logic            any, ie, flush;
   logic [2:0]      mask;
   logic [VEC_W-1:0] vec_sel;
   logic            maskable_take;

   assign raw = {rq_gen_i, rq_c_i, rq_b_i, rq_a_i, nmi_i};

   generate
      for (genvar i = 0; i < int'(NSRC); i++) begin : g_src
         irq_cond #(.MODE(trig_of(i))) u_cond (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (raw[i]),
            .consume_i(consume[i]),
            .flush_i  (flush & (i == 1)),
            .pend_o   (pend[i])
         );
         if (i == 0) begin : g_nmi
            assign elig[i] = pend[i];
         end else if (i < int'(NFIX)) begin : g_fixed
            assign elig[i] = pend[i] & ~mask[i-1] & ie;
         end else begin : g_general
            assign elig[i] = pend[i] & ie;
         end
      end
   endgenerate

   irq_pick #(.N(NSRC)) u_pick (
      .req_i  (elig),
      .grant_o(grant),
      .any_o  (any)
   );

   assign consume       = grant & {NSRC{sample_i}};
   assign maskable_take = sample_i & any & ~grant[0];

   irq_cfg u_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .we_i           (cfg_we_i),
      .data_i         (cfg_word_t'(cfg_data_i)),
      .maskable_take_i(maskable_take),
      .mask_o         (mask),
      .ie_o           (ie),
      .flush_o        (flush)
   );

   always_comb begin
      vec_sel = '0;
      for (int i = 0; i < int'(NFIX); i++)
         if (grant[i]) vec_sel = vec_sel | FIX_VEC[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o <= 1'b0;
         ext_o  <= 1'b0;
         vec_o  <= '0;
      end else begin
         take_o <= sample_i & any;
         ext_o  <= sample_i & grant[GEN_IDX];
         vec_o  <= sample_i ? vec_sel : '0;
      end
   end

   assign status_o = {pend[3], pend[2], pend[1], pend[0], ie, mask};

   // R1: an armed trap wins whatever else is eligible
   a_r1_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_i && pend[0]) |=> (take_o && !ext_o && vec_o == FIX_VEC[0]));
   // R6: device-vectored accept carries no fixed address
   a_r6_ext_no_vec: assert property (@(posedge clk) disable iff (!rst_n)
      ext_o |-> (take_o && vec_o == '0));
   // R7: at most one source granted
   a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R9: with the enable off only the trap can be accepted
   a_r9_ie_gates: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_i && !ie && !pend[0]) |=> !take_o);
   // R11: an accept strobe always follows a sample
   a_r11_take_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(sample_i));

endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nmi_i = 1'b0, rq_a_i = 1'b0, rq_b_i = 1'b0, rq_c_i = 1'b0, rq_gen_i = 1'b0;
   logic       sample_i = 1'b0, cfg_we_i = 1'b0;
   logic [6:0] cfg_data_i = '0;
   logic       take_o, ext_o;
   logic [7:0] vec_o, status_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   bit smp_d = 0;

   typedef struct {
      bit         take;
      bit         ext;
      logic [7:0] vec;
      string      tag;
   } exp_t;
   exp_t q[$];

   vec_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .rq_a_i(rq_a_i), .rq_b_i(rq_b_i),
      .rq_c_i(rq_c_i), .rq_gen_i(rq_gen_i), .sample_i(sample_i), .cfg_we_i(cfg_we_i),
      .cfg_data_i(cfg_data_i), .take_o(take_o), .vec_o(vec_o), .ext_o(ext_o),
      .status_o(status_o));

   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   // driver: one sampling cycle plus its expected outcome
   task automatic smp(input bit take, input bit ext, input logic [7:0] vec, input string tag);
      exp_t e;
      e.take = take; e.ext = ext; e.vec = vec; e.tag = tag;
      q.push_back(e);
      sample_i = 1'b1;
      tick();
      sample_i = 1'b0;
   endtask

   task automatic cfg(input logic [6:0] v);
      cfg_we_i = 1'b1; cfg_data_i = v;
      tick();
      cfg_we_i = 1'b0; cfg_data_i = '0;
   endtask

   always @(posedge clk) smp_d <= sample_i;

   // monitor: compare every sampling result against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (smp_d) begin
            exp_t e;
            if (q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R11 scoreboard empty actual=%0h expected=none", {take_o, ext_o, vec_o});
            end else begin
               e = q.pop_front();
               chk(e.tag, {22'd0, take_o, ext_o, vec_o}, {22'd0, e.take, e.ext, e.vec});
            end
         end else if (take_o) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 unsampled take actual=1 expected=0");
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      chk("R12 reset status", status_o, 8'h00);
      chk("R11 reset take", take_o, 0);
      smp(0, 0, 8'h00, "R11 idle sample");

      rq_b_i = 1; tick();
      chk("R12 rq_b raw bit6", status_o[6], 1);
      smp(0, 0, 8'h00, "R9 enable off blocks rq_b");
      cfg(7'h60);
      chk("R9 enable set", status_o[3], 1);
      smp(1, 0, 8'h34, "R5 rq_b level vector");
      chk("R9 accept clears enable", status_o[3], 0);
      rq_b_i = 0;

      rq_c_i = 1; cfg(7'h60);
      smp(1, 0, 8'h2C, "R5 rq_c level vector");
      cfg(7'h60);
      rq_c_i = 1; tick(); rq_c_i = 0;
      smp(0, 0, 8'h00, "R5 dropped level not kept");

      rq_a_i = 1; tick(); rq_a_i = 0; tick();
      chk("R4 latch holds after fall", status_o[5], 1);
      smp(1, 0, 8'h3C, "R4 latched edge vector");
      chk("R4 service clears latch", status_o[5], 0);

      cfg(7'h60); rq_gen_i = 1; tick();
      smp(1, 1, 8'h00, "R6 general device vector");
      rq_gen_i = 0;

      rq_a_i = 1; rq_b_i = 1; rq_c_i = 1; rq_gen_i = 1; cfg(7'h60); rq_a_i = 0; tick();
      smp(1, 0, 8'h3C, "R7 rq_a first");
      cfg(7'h60);
      smp(1, 0, 8'h34, "R7 rq_b second");
      cfg(7'h6A);
      smp(1, 0, 8'h2C, "R8 rq_b masked");
      cfg(7'h6E);
      smp(1, 1, 8'h00, "R8 rq_b rq_c masked");
      chk("R12 mask bits", status_o[2:0], 3'b110);
      rq_b_i = 0; rq_c_i = 0; rq_gen_i = 0; cfg(7'h08);

      cfg(7'h69);
      rq_a_i = 1; tick(); rq_a_i = 0; tick();
      chk("R8 masked edge stays latched", status_o[5], 1);
      smp(0, 0, 8'h00, "R8 rq_a masked");
      chk("R8 latch after masked sample", status_o[5], 1);
      cfg(7'h10);
      chk("R10 discard clears latch", status_o[5], 0);
      cfg(7'h68);
      smp(0, 0, 8'h00, "R10 no fire after discard");

      cfg(7'h2F);
      nmi_i = 1; tick();
      chk("R12 trap armed bit4", status_o[4], 1);
      smp(1, 0, 8'h24, "R1 trap ignores masks and enable");
      smp(0, 0, 8'h00, "R3 held pulse no second trap");
      nmi_i = 0; tick(); nmi_i = 1; tick();
      smp(1, 0, 8'h24, "R3 re-armed after low");
      nmi_i = 0; tick();

      cfg(7'h68);
      rq_b_i = 1; nmi_i = 1; tick();
      smp(1, 0, 8'h24, "R7 trap over rq_b");
      chk("R9 trap keeps enable", status_o[3], 1);
      smp(1, 0, 8'h34, "R7 rq_b after trap");
      rq_b_i = 0; nmi_i = 0; tick();

      nmi_i = 1; tick(); nmi_i = 0;
      smp(0, 0, 8'h00, "R2 trap fell before sample");
      smp(0, 0, 8'h00, "R2 dropped trap stays gone");

      tick(3);
      chk("R11 scoreboard drained", q.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule